// File: doc/BRIEF.md
# Receive Byte Queue with Fill-Level Interrupt

This block sits between a serial receiver and the CPU. Each byte that the receive shift register completes is offered on a valid/ready input stream and stored in a 16-entry first-in first-out queue. The CPU drains the queue through a valid/ready output stream, in which the read strobe acts as the ready signal. The current fill count and a data-ready flag are always visible.

A data-available interrupt asserts when the fill count reaches a threshold picked by a 2-bit select field and the interrupt is enabled. The CPU can therefore let several bytes collect before it is called. Storing continues past the threshold until all 16 entries are used. A byte that arrives while the queue is full is discarded and sets a sticky overrun flag. A dedicated clear strobe resets that flag. A flush input empties the queue in one clock.

Back-pressure rules: `in_ready` is low when 16 bytes are held and no read takes place in the same cycle, and also while `flush` is high. The receiver cannot stall, so a byte offered while `in_ready` is low is lost rather than held. On the output side, a byte leaves the queue in every cycle where `out_valid` and `out_ready` are both high. `out_data` always shows the oldest byte while `out_valid` is high.

Top module: `rxq_top`

## Requirements
- R1: After reset, fill_count is 0 and out_valid, irq and overrun are all 0.
- R2: Bytes leave in the order they were accepted. While out_valid is high, out_data is the oldest byte held.
- R3: The queue holds at most 16 bytes. in_ready is low when 16 are held and out_ready is low.
- R4: Suppose in_valid is high, 16 bytes are held, and there is neither a read nor a flush. The byte is dropped, the stored contents do not change, fill_count stays 16, and overrun reads 1 from the next cycle on.
- R5: Suppose the queue is full and a write and a read occur in the same cycle. The read is applied first, so the incoming byte is stored, fill_count stays 16, and overrun is not set.
- R6: trig_sel selects the trigger level: code 0 is 1 byte, code 1 is 4, code 2 is 8 and code 3 is 14. irq is 1 exactly when irq_en is 1 and fill_count is at least the selected level.
- R7: While fill_count is below the selected level, irq stays 0 and the bytes stay buffered. irq falls in the same cycle that a read brings fill_count below the level.
- R8: With irq_en at 0, irq is 0 at any fill level.
- R9: overrun stays 1 until a cycle with overrun_clr high, and reads 0 after that cycle. If a drop and a clear happen in the same cycle, overrun stays 1.
- R10: When flush is high, fill_count is 0 on the next cycle and overrun keeps its value. A byte offered in the flush cycle is discarded and does not set overrun.
- R11: A read while the queue is empty has no effect: fill_count stays 0 and out_valid stays 0.
- R12: fill_count always equals the number of bytes accepted minus the number of bytes read since the last reset or flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Receiver has a completed byte |
| in_data | input | 8 | Completed byte |
| in_ready | output | 1 | Byte will be stored this cycle |
| out_valid | output | 1 | Data-ready flag: queue not empty |
| out_data | output | 8 | Oldest byte held |
| out_ready | input | 1 | CPU read strobe |
| fill_count | output | 5 | Number of bytes held, 0 to 16 |
| trig_sel | input | 2 | Trigger level code |
| irq_en | input | 1 | Data-available interrupt enable |
| irq | output | 1 | Data-available interrupt |
| overrun | output | 1 | Sticky overrun flag |
| overrun_clr | input | 1 | Clears overrun |
| flush | input | 1 | Empties the queue |

## Verification
The bench builds the block with its default parameters: 8-bit data, a depth of 16, and trigger levels 1, 4, 8 and 14. With these values every threshold, including 14, is reached within a few dozen cycles. The bench fills the queue to 16 bytes several times, which covers dropped bytes, a simultaneous write and read on a full queue, and a flush while overrun is set. It also reads back the whole queue, which shows that the dropped bytes are missing and the order is kept across pointer wrap-around.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef enum logic [1:0] {
    TRIG_CODE_A = 2'd0,
    TRIG_CODE_B = 2'd1,
    TRIG_CODE_C = 2'd2,
    TRIG_CODE_D = 2'd3
  } trig_code_e;

  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
  } rxq_ctl_t;

  function automatic int unsigned pick_level(input int unsigned idx,
                                             input int unsigned l0,
                                             input int unsigned l1,
                                             input int unsigned l2,
                                             input int unsigned l3);
    case (idx)
      0:       return l0;
      1:       return l1;
      2:       return l2;
      default: return l3;
    endcase
  endfunction

endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
(
  input  logic     in_valid,
  input  logic     out_ready,
  input  logic     flush,
  input  logic     full,
  input  logic     empty,
  output rxq_ctl_t ctl,
  output logic     in_ready,
  output logic     drop
);

  logic pop_ok;
  logic room;

  always_comb begin
    pop_ok    = out_ready && !empty && !flush;
    room      = !flush && (!full || pop_ok);
    in_ready  = room;
    ctl.pop   = pop_ok;
    ctl.push  = in_valid && room;
    ctl.clear = flush;
    drop      = in_valid && !flush && full && !pop_ok;
  end

endmodule

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rxq_ctl_t          ctl,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty
);

  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] wr_ptr_q;
  logic [PTR_W-1:0] rd_ptr_q;
  logic [CNT_W-1:0] count_q;
  logic [DEPTH-1:0][DATA_W-1:0] ents;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [DATA_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (ctl.push && !ctl.clear && wr_ptr_q == PTR_W'(i)) begin
        slot_q <= wr_data;
      end
    end
    assign ents[i] = slot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (ctl.clear) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (ctl.push) wr_ptr_q <= bump(wr_ptr_q);
      if (ctl.pop)  rd_ptr_q <= bump(rd_ptr_q);
      case ({ctl.push, ctl.pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign rd_data = ents[rd_ptr_q];
  assign count   = count_q;
  assign full    = (count_q == CNT_W'(DEPTH));
  assign empty   = (count_q == '0);

endmodule

// File: rtl/rxq_trigger.sv
module rxq_trigger
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LVL0  = 1,
  parameter int unsigned LVL1  = 4,
  parameter int unsigned LVL2  = 8,
  parameter int unsigned LVL3  = 14,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0] count,
  input  logic [1:0]       sel,
  input  logic             en,
  output logic             irq
);

  logic [3:0] reached;

  for (genvar i = 0; i < 4; i++) begin : g_lvl
    localparam int unsigned LVL = pick_level(i, LVL0, LVL1, LVL2, LVL3);
    assign reached[i] = (count >= CNT_W'(LVL));
  end

  trig_code_e code;
  assign code = trig_code_e'(sel);
  assign irq  = en && reached[code];

endmodule

// File: rtl/rxq_overrun.sv
module rxq_overrun (
  input  logic clk,
  input  logic rst_n,
  input  logic drop,
  input  logic clr,
  output logic flag
);

  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (drop)  flag_q <= 1'b1;
    else if (clr)   flag_q <= 1'b0;
  end

  assign flag = flag_q;

endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned LVL0   = 1,
  parameter int unsigned LVL1   = 4,
  parameter int unsigned LVL2   = 8,
  parameter int unsigned LVL3   = 14,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready,
  output logic [CNT_W-1:0]  fill_count,
  input  logic [1:0]        trig_sel,
  input  logic              irq_en,
  output logic              irq,
  output logic              overrun,
  input  logic              overrun_clr,
  input  logic              flush
);

  rxq_ctl_t ctl;
  logic     full;
  logic     empty;
  logic     drop;

  rxq_ctrl i_ctrl (
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .flush     (flush),
    .full      (full),
    .empty     (empty),
    .ctl       (ctl),
    .in_ready  (in_ready),
    .drop      (drop)
  );

  rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl     (ctl),
    .wr_data (in_data),
    .rd_data (out_data),
    .count   (fill_count),
    .full    (full),
    .empty   (empty)
  );

  rxq_trigger #(
    .DEPTH(DEPTH), .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3)
  ) i_trig (
    .count (fill_count),
    .sel   (trig_sel),
    .en    (irq_en),
    .irq   (irq)
  );

  rxq_overrun i_ovr (
    .clk   (clk),
    .rst_n (rst_n),
    .drop  (drop),
    .clr   (overrun_clr),
    .flag  (overrun)
  );

  assign out_valid = !empty;

endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_ready,
  input logic [CNT_W-1:0]  fill_count,
  input logic [1:0]        trig_sel,
  input logic              irq_en,
  input logic              irq,
  input logic              overrun,
  input logic              overrun_clr,
  input logic              flush
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_count <= FULL_CNT);

  // R3
  full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_count == FULL_CNT && !out_ready) |-> !in_ready);

  // R4
  drop_sets_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fill_count == FULL_CNT && !out_ready && !flush)
      |=> (overrun && fill_count == FULL_CNT && $stable(out_data)));

  // R5
  full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fill_count == FULL_CNT && out_ready && !flush && !overrun)
      |=> (!overrun && fill_count == FULL_CNT));

  // R6
  lvl_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && trig_sel == 2'd0 && fill_count != '0) |-> irq);

  // R7
  below_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> out_valid);

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

  // R9
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !overrun_clr) |=> overrun);

  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !overrun_clr) |=> (fill_count == '0 && overrun == $past(overrun)));

  // R11
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_count == '0 && !in_valid) |=> (fill_count == '0 && !out_valid));

endmodule

bind rxq_top rxq_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_data    (out_data),
  .out_ready   (out_ready),
  .fill_count  (fill_count),
  .trig_sel    (trig_sel),
  .irq_en      (irq_en),
  .irq         (irq),
  .overrun     (overrun),
  .overrun_clr (overrun_clr),
  .flush       (flush)
);

// File: tb/test_rxq_top.sv
module test_rxq_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_ready = 1'b0;
  logic [4:0] fill_count;
  logic [1:0] trig_sel = 2'd0;
  logic       irq_en = 1'b0;
  logic       irq;
  logic       overrun;
  logic       overrun_clr = 1'b0;
  logic       flush = 1'b0;

  int nchk = 0;
  int nfail = 0;
  logic [7:0] exp_q[$];
  logic ovr_exp = 1'b0;

  always #4 clk = ~clk;

  rxq_top i_rxq_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .fill_count(fill_count), .trig_sel(trig_sel),
    .irq_en(irq_en), .irq(irq), .overrun(overrun),
    .overrun_clr(overrun_clr), .flush(flush)
  );

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int level_of(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  // monitor: compares every read against the scoreboard head (R2)
  always @(negedge clk) begin
    if (rst_n && out_ready && !flush && exp_q.size() > 0) begin
      check("R2 out_valid", int'(out_valid), 1);
      check("R2 out_data", int'(out_data), int'(exp_q[0]));
      void'(exp_q.pop_front());
    end
  end

  // driver: one cycle of stimulus, starting just after a rising edge
  task automatic step(input logic iv, input logic [7:0] d, input logic rd,
                      input logic fl, input logic clr);
    bit acc;
    bit drp;
    in_valid = iv; in_data = d; out_ready = rd; flush = fl; overrun_clr = clr;
    acc = iv && !fl && (exp_q.size() < 16 || (rd && exp_q.size() > 0));
    drp = iv && !fl && !acc;
    @(posedge clk);
    if (fl) exp_q.delete();
    else if (acc) exp_q.push_back(d);
    if (drp) ovr_exp = 1'b1;
    else if (clr) ovr_exp = 1'b0;
    #1;
    in_valid = 1'b0; out_ready = 1'b0; flush = 1'b0; overrun_clr = 1'b0;
  endtask

  task automatic push(input logic [7:0] d);
    step(1'b1, d, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic pull();
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic check_state(input string tag);
    @(negedge clk);
    check({tag, " fill_count"}, int'(fill_count), exp_q.size());
    check({tag, " overrun"}, int'(overrun), int'(ovr_exp));
    check({tag, " irq"}, int'(irq),
          int'(irq_en && exp_q.size() >= level_of(trig_sel)));
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 fill_count", int'(fill_count), 0);
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 irq", int'(irq), 0);
    check("R1 overrun", int'(overrun), 0);
    rst_n = 1'b1;
    @(posedge clk);
    #1;

    // R6 level 1, R7 drop on read
    irq_en = 1'b1; trig_sel = 2'd0;
    push(8'hA5);
    check_state("R6 lvl1");
    pull();
    check_state("R7 lvl1 read");

    // R11 read on empty
    pull();
    check_state("R11");
    check("R11 out_valid", int'(out_valid), 0);

    // R7 below level 4, then R6 reach it, R8 gate
    trig_sel = 2'd1;
    for (int i = 0; i < 3; i++) push(8'h10 + 8'(i));
    check_state("R7 below4");
    push(8'h13);
    check_state("R6 lvl4");
    irq_en = 1'b0;
    check_state("R8");
    irq_en = 1'b1;

    // R6 level 8 and 14
    trig_sel = 2'd2;
    for (int i = 0; i < 3; i++) push(8'h20 + 8'(i));
    check_state("R7 below8");
    push(8'h23);
    check_state("R6 lvl8");
    trig_sel = 2'd3;
    for (int i = 0; i < 5; i++) push(8'h30 + 8'(i));
    check_state("R7 below14");
    push(8'h35);
    check_state("R6 lvl14");

    // R12 fill to capacity, R3 back-pressure
    push(8'h40); push(8'h41);
    check_state("R12 full");
    @(negedge clk);
    check("R3 in_ready", int'(in_ready), 0);
    @(posedge clk); #1;

    // R4 dropped bytes
    push(8'hEE); push(8'hEF);
    check_state("R4");

    // R7 read under 14 drops irq
    pull(); pull(); pull();
    check_state("R7 read below14");

    // R2 drain all: dropped bytes must not appear
    while (exp_q.size() > 0) pull();
    check_state("R2 drained");

    // R9 clear, and set-wins-over-clear
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    check_state("R9 clear");
    for (int i = 0; i < 16; i++) push(8'h50 + 8'(i));
    step(1'b1, 8'hDD, 1'b0, 1'b0, 1'b1);
    check_state("R9 set wins");
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    check_state("R9 clear2");

    // R5 simultaneous write and read on full
    step(1'b1, 8'h77, 1'b1, 1'b0, 1'b0);
    check_state("R5");
    step(1'b1, 8'h78, 1'b1, 1'b0, 1'b0);
    check_state("R5 again");

    // R10 flush with overrun set, byte during flush dropped
    push(8'hCC);
    check_state("R10 pre");
    step(1'b1, 8'h99, 1'b0, 1'b1, 1'b0);
    check_state("R10 flush");
    check("R10 out_valid", int'(out_valid), 0);

    // R12 refill after flush, order after wrap (R2)
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    trig_sel = 2'd1;
    for (int i = 0; i < 5; i++) push(8'h60 + 8'(i));
    check_state("R12 refill");
    while (exp_q.size() > 0) pull();
    check_state("R12 empty");

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule